// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial-link PHY out of reset through its control-register port, then waits until the receive PLL reports lock. It does not perform the register handshake itself. It issues one request at a time to a separate register master: an address capture, a data write or a data read. It then waits for that master's completion, error flag and read data.

A run begins with a start pulse. If the pre-reset flag is set, the block first works two sideband lines. It releases the power-down line, pulls the software reset line low, and then raises it again, holding each level for a programmable number of cycles. Next it resets the PHY. To do that it captures the clock/reset register address and writes the reset value into it.

After that the block enters a polling loop. Each pass starts with an idle gap. It then addresses the lane status register, reads it, and tests the lock bit. The run ends in one of three ways: lock is seen, the attempt budget runs out, or the register master reports an error. The outcome is given by a one-cycle done pulse that carries exactly one status flag. The block then returns to idle.

Top module: `phy_rst_lock_seq`

## Requirements
- R1: While reset is asserted, `req_valid_o` and `done_o` are 0, and both `pwr_down_o` and `sw_rst_o` are 1.
- R2: With `prereset_en_i` high at start, the lines change in this order before the first register request: `pwr_down_o` falls, `sw_rst_o` falls, `sw_rst_o` rises. The interval between consecutive events, and from the last event to the first request, is at least HOLD_CYCLES cycles. Afterwards `pwr_down_o` stays 0 and `sw_rst_o` stays 1.
- R3: With `prereset_en_i` low at start, neither sideband line changes. The first request appears in the cycle after start is sampled.
- R4: The first two requests are an address capture and then a write. Opcodes on `req_op_o` are 1 for address, 2 for write and 3 for read. The address capture carries 16'h7F3F and the write carries 16'h0001.
- R5: Before each lane-status address request, `req_valid_o` is low for at least POLL_GAP cycles.
- R6: Each poll is an address request carrying 16'h2003, followed by a read request carrying 16'h0000. A read returned without error and with bit 1 of the read data set ends the run with `ok_o`.
- R7: If none of MAX_POLLS reads shows bit 1 set, the run ends with `timeout_o` after exactly MAX_POLLS reads.
- R8: An error flag on any completed request ends the run with `fail_o`, and no further request is issued. An error takes priority over a lock bit returned in the same response.
- R9: `done_o` is high for exactly one cycle per run, together with exactly one of `ok_o`, `timeout_o` and `fail_o`. While a run is in progress, `start_i` is ignored.
- R10: A request keeps `req_valid_o`, `req_op_o` and `req_data_o` unchanged until a cycle with `rsp_done_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run when idle |
| prereset_en_i | input | 1 | Work the sideband lines before the register reset |
| req_valid_o | output | 1 | Request to the register master is pending |
| req_op_o | output | 2 | Request kind: 1 address, 2 write, 3 read |
| req_data_o | output | DATA_W | Address or write value of the request |
| rsp_done_i | input | 1 | Register master completed the pending request |
| rsp_err_i | input | 1 | Completed request failed |
| rsp_rdata_i | input | DATA_W | Read data of a completed read |
| pwr_down_o | output | 1 | Software power-down line |
| sw_rst_o | output | 1 | Software reset line |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | Run ended with PLL lock |
| timeout_o | output | 1 | Run ended with the poll budget spent |
| fail_o | output | 1 | Run ended on a register-master error |

## Verification
Lock detection and error abort can both fall on the same read response. When they do, the block must pick one outcome. The bench arranges this by answering a read with the lock bit set and the error flag raised together. The run must then end with `fail_o`, `ok_o` must stay clear, and no request may follow. A second overlap exists between a start pulse and a busy sequencer. The bench holds start for two sampled edges in every run and then requires a single done pulse and an unchanged request log.

// File: rtl/phy_rst_lock_pkg.sv
package phy_rst_lock_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_ADDR  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } req_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PD_LOW,
      ST_RST_LOW,
      ST_RST_HIGH,
      ST_RST_ADDR,
      ST_RST_WR,
      ST_GAP,
      ST_POLL_ADDR,
      ST_POLL_RD
   } seq_state_e;

   typedef enum logic [1:0] {
      END_OK,
      END_TMO,
      END_FAIL
   } end_kind_e;

endpackage

// File: rtl/prl_countdown.sv
module prl_countdown #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= val_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/prl_attempts.sv
module prl_attempts #(
   parameter int LIMIT = 8,
   parameter int W     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (inc_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == W'(LIMIT - 1));

endmodule

// File: rtl/prl_lines.sv
module prl_lines #(
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_pd_i,
   input  logic clr_rst_i,
   input  logic set_rst_i,
   output logic pd_o,
   output logic rst_o
);

   generate
      if (ENABLE) begin : g_driven
         logic pd_q, rst_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pd_q  <= 1'b1;
               rst_q <= 1'b1;
            end else begin
               if (clr_pd_i)  pd_q  <= 1'b0;
               if (clr_rst_i) rst_q <= 1'b0;
               else if (set_rst_i) rst_q <= 1'b1;
            end
         end
         assign pd_o  = pd_q;
         assign rst_o = rst_q;
      end else begin : g_tied
         assign pd_o  = 1'b1;
         assign rst_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/phy_rst_lock_seq.sv
module phy_rst_lock_seq
   import phy_rst_lock_pkg::*;
#(
   parameter int          DATA_W       = 16,
   parameter int          MAX_POLLS    = 8,
   parameter int          POLL_GAP     = 20,
   parameter int          HOLD_CYCLES  = 4,
   parameter bit          HAS_PRERESET = 1'b1,
   parameter logic [15:0] RST_REG      = 16'h7F3F,
   parameter logic [15:0] RST_VAL      = 16'h0001,
   parameter logic [15:0] LANE_REG     = 16'h2003,
   parameter logic [15:0] LOCK_MASK    = 16'h0002
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              prereset_en_i,
   output logic              req_valid_o,
   output logic [1:0]        req_op_o,
   output logic [DATA_W-1:0] req_data_o,
   input  logic              rsp_done_i,
   input  logic              rsp_err_i,
   input  logic [DATA_W-1:0] rsp_rdata_i,
   output logic              pwr_down_o,
   output logic              sw_rst_o,
   output logic              done_o,
   output logic              ok_o,
   output logic              timeout_o,
   output logic              fail_o
);

   localparam int TMR_MAX = (HOLD_CYCLES > POLL_GAP) ? HOLD_CYCLES : POLL_GAP;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam int ATT_W   = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

   if (MAX_POLLS < 1)   begin : g_bad_polls $error("MAX_POLLS must be at least 1"); end
   if (POLL_GAP < 1)    begin : g_bad_gap   $error("POLL_GAP must be at least 1"); end
   if (HOLD_CYCLES < 1) begin : g_bad_hold  $error("HOLD_CYCLES must be at least 1"); end
   if (DATA_W < 16)     begin : g_bad_width $error("DATA_W must be at least 16"); end
   if (LOCK_MASK == '0) begin : g_bad_mask  $error("LOCK_MASK must be non-zero"); end

   seq_state_e          st_q, st_d;
   logic                tmr_load, tmr_zero;
   logic [TMR_W-1:0]    tmr_val;
   logic                att_clr, att_inc, att_last;
   logic                clr_pd, clr_rst, set_rst;
   logic                fin;
   end_kind_e           fin_kind;
   logic                accept, locked, go_pre;
   logic                done_q, ok_q, tmo_q, fail_q;

   assign accept = req_valid_o & rsp_done_i;
   assign locked = |(rsp_rdata_i & DATA_W'(LOCK_MASK));
   assign go_pre = prereset_en_i & HAS_PRERESET;

   // request presentation follows the registered state only
   always_comb begin
      req_valid_o = 1'b1;
      req_op_o    = OP_NONE;
      req_data_o  = '0;
      case (st_q)
         ST_RST_ADDR:  begin req_op_o = OP_ADDR;  req_data_o = DATA_W'(RST_REG);  end
         ST_RST_WR:    begin req_op_o = OP_WRITE; req_data_o = DATA_W'(RST_VAL);  end
         ST_POLL_ADDR: begin req_op_o = OP_ADDR;  req_data_o = DATA_W'(LANE_REG); end
         ST_POLL_RD:   begin req_op_o = OP_READ;  end
         default:      req_valid_o = 1'b0;
      endcase
   end

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      att_clr  = 1'b0;
      att_inc  = 1'b0;
      clr_pd   = 1'b0;
      clr_rst  = 1'b0;
      set_rst  = 1'b0;
      fin      = 1'b0;
      fin_kind = END_OK;
      case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               if (go_pre) begin
                  st_d     = ST_PD_LOW;
                  clr_pd   = 1'b1;
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(HOLD_CYCLES);
               end else begin
                  st_d = ST_RST_ADDR;
               end
            end
         end
         ST_PD_LOW: begin
            if (tmr_zero) begin
               st_d     = ST_RST_LOW;
               clr_rst  = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(HOLD_CYCLES);
            end
         end
         ST_RST_LOW: begin
            if (tmr_zero) begin
               st_d     = ST_RST_HIGH;
               set_rst  = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(HOLD_CYCLES);
            end
         end
         ST_RST_HIGH: begin
            if (tmr_zero) st_d = ST_RST_ADDR;
         end
         ST_RST_ADDR: begin
            if (accept) begin
               if (rsp_err_i) begin fin = 1'b1; fin_kind = END_FAIL; end
               else st_d = ST_RST_WR;
            end
         end
         ST_RST_WR: begin
            if (accept) begin
               if (rsp_err_i) begin
                  fin = 1'b1; fin_kind = END_FAIL;
               end else begin
                  st_d     = ST_GAP;
                  att_clr  = 1'b1;
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(POLL_GAP);
               end
            end
         end
         ST_GAP: begin
            if (tmr_zero) st_d = ST_POLL_ADDR;
         end
         ST_POLL_ADDR: begin
            if (accept) begin
               if (rsp_err_i) begin fin = 1'b1; fin_kind = END_FAIL; end
               else st_d = ST_POLL_RD;
            end
         end
         ST_POLL_RD: begin
            if (accept) begin
               if (rsp_err_i) begin
                  fin = 1'b1; fin_kind = END_FAIL;
               end else if (locked) begin
                  fin = 1'b1; fin_kind = END_OK;
               end else if (att_last) begin
                  fin = 1'b1; fin_kind = END_TMO;
               end else begin
                  st_d     = ST_GAP;
                  att_inc  = 1'b1;
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(POLL_GAP);
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
      if (fin) st_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         done_q <= 1'b0;
         ok_q   <= 1'b0;
         tmo_q  <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= fin;
         ok_q   <= fin & (fin_kind == END_OK);
         tmo_q  <= fin & (fin_kind == END_TMO);
         fail_q <= fin & (fin_kind == END_FAIL);
      end
   end

   assign done_o    = done_q;
   assign ok_o      = ok_q;
   assign timeout_o = tmo_q;
   assign fail_o    = fail_q;

   prl_countdown #(.W(TMR_W)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   prl_attempts #(.LIMIT(MAX_POLLS), .W(ATT_W)) i_attempts (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (att_clr),
      .inc_i  (att_inc),
      .last_o (att_last)
   );

   prl_lines #(.ENABLE(HAS_PRERESET)) i_lines (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_pd_i  (clr_pd),
      .clr_rst_i (clr_rst),
      .set_rst_i (set_rst),
      .pd_o      (pwr_down_o),
      .rst_o     (sw_rst_o)
   );

endmodule

// File: rtl/phy_rst_lock_seq_chk.sv
module phy_rst_lock_seq_chk #(
   parameter int          DATA_W    = 16,
   parameter logic [15:0] LOCK_MASK = 16'h0002
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic [DATA_W-1:0] req_data,
   input logic              rsp_done,
   input logic              rsp_err,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              pwr_down,
   input logic              sw_rst,
   input logic              done,
   input logic              ok,
   input logic              tmo,
   input logic              fail
);

   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_done) |=> (req_valid && $stable(req_op) && $stable(req_data)));

   a_r9_one_status: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($countones({ok, tmo, fail}) == 1));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_err_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rsp_done && rsp_err) |=> (done && fail && !req_valid));

   a_r6_lock_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'd3 && rsp_done && !rsp_err &&
       |(rsp_rdata & DATA_W'(LOCK_MASK))) |=> (done && ok));

   a_r2_rst_low_after_pd: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_rst) |-> !pwr_down);

endmodule

bind phy_rst_lock_seq phy_rst_lock_seq_chk #(
   .DATA_W    (DATA_W),
   .LOCK_MASK (LOCK_MASK)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid_o),
   .req_op    (req_op_o),
   .req_data  (req_data_o),
   .rsp_done  (rsp_done_i),
   .rsp_err   (rsp_err_i),
   .rsp_rdata (rsp_rdata_i),
   .pwr_down  (pwr_down_o),
   .sw_rst    (sw_rst_o),
   .done      (done_o),
   .ok        (ok_o),
   .tmo       (timeout_o),
   .fail      (fail_o)
);

// File: tb/test_phy_rst_lock_seq.sv
module test_phy_rst_lock_seq;

   localparam int MAXP = 4;
   localparam int GAP  = 3;
   localparam int HOLD = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        prereset_en_i = 1'b0;
   logic        req_valid_o;
   logic [1:0]  req_op_o;
   logic [15:0] req_data_o;
   logic        rsp_done_i = 1'b0;
   logic        rsp_err_i = 1'b0;
   logic [15:0] rsp_rdata_i = 16'h0;
   logic        pwr_down_o, sw_rst_o, done_o, ok_o, timeout_o, fail_o;

   always #4 clk = ~clk;

   phy_rst_lock_seq #(
      .DATA_W(16), .MAX_POLLS(MAXP), .POLL_GAP(GAP), .HOLD_CYCLES(HOLD)
   ) i_phy_rst_lock_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .prereset_en_i(prereset_en_i),
      .req_valid_o(req_valid_o), .req_op_o(req_op_o), .req_data_o(req_data_o),
      .rsp_done_i(rsp_done_i), .rsp_err_i(rsp_err_i), .rsp_rdata_i(rsp_rdata_i),
      .pwr_down_o(pwr_down_o), .sw_rst_o(sw_rst_o), .done_o(done_o),
      .ok_o(ok_o), .timeout_o(timeout_o), .fail_o(fail_o)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // register-master model configuration and log
   int lock_at = 0, err_at = 0, lat = 0, nops = 0, rd_idx = 0;
   logic [1:0]  log_op  [0:31];
   logic [15:0] log_dat [0:31];

   // line / gap monitor state
   bit in_run = 1'b0;
   int t_pdf, t_rf, t_rr, t_req, line_chg, idle_run, min_idle;
   logic prev_pd, prev_rst, prev_req;

   task automatic chk(input bit c, input string tag, input int act, input int exp);
      checks++;
      if (!c) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (req_valid_o && rst_n) begin
            repeat (lat) @(negedge clk);
            if (nops < 32) begin
               log_op[nops]  = req_op_o;
               log_dat[nops] = req_data_o;
            end
            nops++;
            rsp_rdata_i = 16'h0;
            if (req_op_o == 2'd3) begin
               rd_idx++;
               rsp_rdata_i = ((16'hA5A5 ^ 16'(rd_idx * 16'h0111)) & 16'hFFFD) |
                             ((rd_idx == lock_at) ? 16'h0002 : 16'h0000);
            end
            rsp_err_i  = (nops == err_at);
            rsp_done_i = 1'b1;
            @(negedge clk);
            rsp_done_i = 1'b0;
            rsp_err_i  = 1'b0;
         end
      end
   end

   always @(negedge clk) begin
      if (in_run) begin
         if (prev_pd !== pwr_down_o || prev_rst !== sw_rst_o) line_chg++;
         if (prev_pd && !pwr_down_o && t_pdf < 0) t_pdf = cyc;
         if (prev_rst && !sw_rst_o && t_rf < 0) t_rf = cyc;
         if (!prev_rst && sw_rst_o && t_rr < 0) t_rr = cyc;
         if (!req_valid_o) idle_run++;
         else begin
            if (!prev_req && t_req >= 0 && idle_run < min_idle) min_idle = idle_run;
            idle_run = 0;
         end
         if (req_valid_o && t_req < 0) t_req = cyc;
         prev_pd  = pwr_down_o;
         prev_rst = sw_rst_o;
         prev_req = req_valid_o;
      end
   end

   task automatic run(input int pre, input int lk, input int ea, input int lt);
      int s_cyc, w, extra_done, extra_req, nat, exp_ops, exp_kind, act_kind, rd;
      string tg;
      rst_n = 1'b0;
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!req_valid_o && !done_o && pwr_down_o && sw_rst_o, "R1 reset state",
          {req_valid_o, done_o, pwr_down_o, sw_rst_o}, 4'b0011);
      rst_n = 1'b1;
      @(negedge clk);
      lock_at = lk; err_at = ea; lat = lt; nops = 0; rd_idx = 0;
      t_pdf = -1; t_rf = -1; t_rr = -1; t_req = -1;
      line_chg = 0; idle_run = 0; min_idle = 1000;
      prev_pd = pwr_down_o; prev_rst = sw_rst_o; prev_req = req_valid_o;
      prereset_en_i = pre[0];
      s_cyc = cyc;
      in_run = 1'b1;
      start_i = 1'b1;           // held over two sampled edges: R9 busy start
      @(negedge clk);
      @(negedge clk);
      start_i = 1'b0;
      w = 0;
      while (!done_o && w < 400) begin
         @(negedge clk);
         w++;
      end
      act_kind = ok_o ? 0 : (timeout_o ? 1 : (fail_o ? 2 : 3));
      extra_done = 0;
      extra_req  = 0;
      repeat (6) begin
         @(negedge clk);
         if (done_o) extra_done++;
         if (req_valid_o) extra_req++;
      end
      in_run = 1'b0;

      rd = (lk <= MAXP) ? lk : MAXP;
      nat = 2 + 2 * rd;
      if (ea != 0 && ea <= nat) begin exp_ops = ea; exp_kind = 2; tg = "R8 error abort"; end
      else if (lk <= MAXP)      begin exp_ops = nat; exp_kind = 0; tg = "R6 lock ok"; end
      else                      begin exp_ops = nat; exp_kind = 1; tg = "R7 timeout"; end

      chk(done_o == 1'b0 && w < 400 && act_kind == exp_kind, tg, act_kind, exp_kind);
      chk(nops == exp_ops, "R7 R8 request count", nops, exp_ops);
      chk(extra_done == 0 && extra_req == 0, "R9 single done then idle",
          extra_done + extra_req, 0);
      for (int i = 0; i < exp_ops && i < nops && i < 32; i++) begin
         logic [1:0]  eo;
         logic [15:0] ed;
         if (i == 0)          begin eo = 2'd1; ed = 16'h7F3F; end
         else if (i == 1)     begin eo = 2'd2; ed = 16'h0001; end
         else if (i % 2 == 0) begin eo = 2'd1; ed = 16'h2003; end
         else                 begin eo = 2'd3; ed = 16'h0000; end
         chk(log_op[i] == eo && log_dat[i] == ed,
             (i < 2) ? "R4 R10 reset access" : "R6 R10 poll access",
             {log_op[i], log_dat[i]}, {eo, ed});
      end
      if (exp_ops >= 3)
         chk(min_idle >= GAP, "R5 poll gap", min_idle, GAP);
      if (pre != 0) begin
         chk(t_pdf >= 0 && t_rf > t_pdf && t_rr > t_rf && t_req > t_rr &&
             (t_rf - t_pdf) >= HOLD && (t_rr - t_rf) >= HOLD && (t_req - t_rr) >= HOLD,
             "R2 line order", t_rr - t_rf, HOLD);
         chk(!pwr_down_o && sw_rst_o, "R2 final levels",
             {pwr_down_o, sw_rst_o}, 2'b01);
      end else begin
         chk(line_chg == 0 && pwr_down_o && sw_rst_o, "R3 lines untouched", line_chg, 0);
         chk(t_req - s_cyc == 1, "R3 immediate request", t_req - s_cyc, 1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // sweep: pre-reset option x lock attempt (MAXP+1 = never) x response latency
      for (int p = 0; p < 2; p++)
         for (int k = 1; k <= MAXP + 1; k++)
            for (int l = 0; l < 3; l++)
               run(p, k, 0, l);
      // error at every request position, lock never
      for (int e = 1; e <= 2 + 2 * MAXP; e++)
         run(e % 2, MAXP + 1, e, 1);
      // R8: error and lock bit in the same read response
      run(0, 1, 4, 1);
      run(1, 2, 6, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule